// File: doc/BRIEF.md
# Incremental SPI Opcode Slot Matcher

This block sits in the front end of an SPI flash device. It watches the first eight bits a host shifts in after chip select falls and decides which entry of a command table those bits name. Each table entry holds an 8-bit opcode, a valid bit and an upload bit. The block does not wait for the whole byte and then compare it against every entry. It keeps one "still possible" bit per entry and clears the bits of entries that disagree as each bit arrives. The eighth bit then needs only a one-bit test on the few survivors and a lowest-index pick.

Two enables leave the block. The upload enable can rise on the falling SCK edge after the seventh bit, half a cycle before the opcode is complete. This lets a single-byte command such as a write-enable or a chip erase be logged without delay. The dispatch enable for the other handlers (read, status, identification) pulses only after the eighth rising edge. Chip select high is the block's asynchronous reset, so every new transaction starts from a clean table.

Top module: `opm_opcode_matcher`

## Requirements
- R1: While `cs_n` is high, `match_valid`, `nomatch`, `dispatch_en` and `upload_en` are 0 and `match_idx` is 0.
- R2: Opcode bits are taken from `sdi` MSB first, one per SCK rising edge, starting with the first rising edge after `cs_n` falls. Slot i's opcode is `slot_opcode[i*8 +: 8]`. When the eighth bit has been sampled and some valid slot's opcode equals the received byte, `match_valid` is 1 and `match_idx` gives that slot. Neither changes before that edge.
- R3: A slot whose `slot_valid` bit is 0 never matches, even when its opcode equals the received byte.
- R4: When several valid slots hold the received opcode, `match_idx` is the lowest-numbered of them.
- R5: `dispatch_en` is 0 until the eighth rising edge. After that edge it is 1 for exactly one SCK cycle on a match, and it stays 0 on a miss.
- R6: `upload_en` is 0 up to the falling SCK edge that follows the seventh opcode bit. At that falling edge it becomes 1 when a valid slot whose opcode agrees with the seven bits received so far has its upload bit set.
- R7: From the eighth rising edge until `cs_n` rises, `upload_en` is 1 only when it had risen early (R6), the byte matched, and the matched slot's `slot_upload` bit is 1. Otherwise it is 0.
- R8: When no valid slot matches after eight bits, `nomatch` is 1 and `match_valid`, `dispatch_en` and `upload_en` are 0. This holds until `cs_n` rises.
- R9: SCK edges after the eighth bit (address, data) leave `match_valid`, `nomatch` and `match_idx` unchanged.
- R10: Raising `cs_n` partway through an opcode discards the partial bits. The next transaction is matched from its own first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; opcode bits sampled on rising edges |
| cs_n | input | 1 | Active-low chip select; high acts as asynchronous reset |
| sdi | input | 1 | Serial data in |
| slot_opcode | input | NumSlots*OpBits | Opcode of slot i at bits [i*OpBits +: OpBits] |
| slot_valid | input | NumSlots | Per-slot enable |
| slot_upload | input | NumSlots | Per-slot upload request |
| match_valid | output | 1 | Opcode resolved to a slot |
| match_idx | output | IdxW | Index of the matched slot |
| nomatch | output | 1 | Opcode resolved, no slot matched |
| dispatch_en | output | 1 | One-cycle enable for the non-upload handlers |
| upload_en | output | 1 | Early upload-path enable |

## Verification
A table of opcodes is played against a fixed 24-slot configuration. The set contains plain single matches, a byte shared by an upload and a non-upload slot (tells lowest-index priority from last-wins), a byte held only by a disabled slot (tells valid qualification apart), and pairs that differ only in the last bit, where one partner has the upload bit and the other does not (tells the early seven-bit upload decision from the final one). For every opcode the outputs are sampled after the seventh rising edge, after the following falling edge and after the eighth rising edge, which separates a half-cycle-early enable from one that is late or too early. Directed runs then send trailing address bits after a hit and after a miss, and abort a transaction partway through an opcode.

// File: rtl/opm_pkg.sv
package opm_pkg;

  // Resolution phase of the current transaction
  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_HIT     = 2'd1,
    PH_MISS    = 2'd2
  } opm_phase_e;

endpackage

// File: rtl/opm_slot_lane.sv
// One candidate bit for one table slot, narrowed bit by bit.
module opm_slot_lane #(
  parameter int unsigned OpBits = 8,
  parameter int unsigned BeatW  = 4
) (
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  input  logic              step_en,
  input  logic [BeatW-1:0]  beat,
  input  logic [OpBits-1:0] opcode,
  input  logic              valid,
  input  logic              upload,
  output logic              alive,
  output logic              last_hit,
  output logic              up_alive
);
  localparam int unsigned PosW = (OpBits > 1) ? $clog2(OpBits) : 1;

  logic [PosW-1:0] pos;
  logic            alive_q, alive_d;

  // MSB first: beat 0 compares the top opcode bit
  assign pos = PosW'(OpBits - 1) - PosW'(beat);

  always_comb begin
    alive_d = alive_q;
    if (step_en) alive_d = alive_q & valid & (opcode[pos] == sdi);
  end

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) alive_q <= 1'b1;
    else      alive_q <= alive_d;
  end

  assign alive    = alive_q;
  // final beat: a single-bit test on the surviving candidate
  assign last_hit = alive_q & valid & (opcode[0] == sdi);
  assign up_alive = alive_q & valid & upload;

endmodule

// File: rtl/opm_lowest_pick.sv
// Lowest-index select over the final candidate vector.
module opm_lowest_pick #(
  parameter int unsigned N    = 24,
  parameter int unsigned IdxW = 5
) (
  input  logic [N-1:0]    req,
  output logic            any,
  output logic [IdxW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IdxW'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/opm_opcode_matcher.sv
module opm_opcode_matcher
  import opm_pkg::*;
#(
  parameter int unsigned NumSlots = 24,
  parameter int unsigned OpBits   = 8,
  localparam int unsigned IdxW    = (NumSlots > 1) ? $clog2(NumSlots) : 1,
  localparam int unsigned BeatW   = $clog2(OpBits + 1)
) (
  input  logic                       sck,
  input  logic                       cs_n,
  input  logic                       sdi,
  input  logic [NumSlots*OpBits-1:0] slot_opcode,
  input  logic [NumSlots-1:0]        slot_valid,
  input  logic [NumSlots-1:0]        slot_upload,
  output logic                       match_valid,
  output logic [IdxW-1:0]            match_idx,
  output logic                       nomatch,
  output logic                       dispatch_en,
  output logic                       upload_en
);
  localparam logic [BeatW-1:0] LastBeat = BeatW'(OpBits - 1);

  opm_phase_e       phase_q, phase_d;
  logic [BeatW-1:0] beat_q, beat_d;
  logic [IdxW-1:0]  idx_q, idx_d;
  logic             upfin_q, upfin_d;
  logic             disp_q, disp_d;
  logic             arm_q, arm_d;

  logic                collecting, step_en, last_beat;
  logic [NumSlots-1:0] alive, last_hit, up_alive;
  logic                pick_any;
  logic [IdxW-1:0]     pick_idx;

  assign collecting = (phase_q == PH_COLLECT);
  assign step_en    = collecting && (beat_q < LastBeat);
  assign last_beat  = collecting && (beat_q == LastBeat);

  // Per-slot candidate lanes
  for (genvar g = 0; g < NumSlots; g++) begin : g_lane
    opm_slot_lane #(.OpBits(OpBits), .BeatW(BeatW)) u_lane (
      .sck      (sck),
      .cs_n     (cs_n),
      .sdi      (sdi),
      .step_en  (step_en),
      .beat     (beat_q),
      .opcode   (slot_opcode[g*OpBits +: OpBits]),
      .valid    (slot_valid[g]),
      .upload   (slot_upload[g]),
      .alive    (alive[g]),
      .last_hit (last_hit[g]),
      .up_alive (up_alive[g])
    );
  end

  opm_lowest_pick #(.N(NumSlots), .IdxW(IdxW)) u_pick (
    .req (last_hit),
    .any (pick_any),
    .idx (pick_idx)
  );

  // Rising-edge next state
  always_comb begin
    phase_d = phase_q;
    beat_d  = beat_q;
    idx_d   = idx_q;
    upfin_d = upfin_q;
    disp_d  = 1'b0;
    if (collecting) beat_d = beat_q + BeatW'(1);
    if (last_beat) begin
      phase_d = pick_any ? PH_HIT : PH_MISS;
      idx_d   = pick_idx;
      upfin_d = pick_any & slot_upload[pick_idx];
      disp_d  = pick_any;
    end
  end

  always_ff @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      phase_q <= PH_COLLECT;
      beat_q  <= '0;
      idx_q   <= '0;
      upfin_q <= 1'b0;
      disp_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      beat_q  <= beat_d;
      idx_q   <= idx_d;
      upfin_q <= upfin_d;
      disp_q  <= disp_d;
    end
  end

  // Falling-edge early upload decision after seven bits
  always_comb begin
    arm_d = arm_q;
    if (last_beat) arm_d = |up_alive;
  end

  always_ff @(negedge sck or posedge cs_n) begin
    if (cs_n) arm_q <= 1'b0;
    else      arm_q <= arm_d;
  end

  assign match_valid = (phase_q == PH_HIT);
  assign nomatch     = (phase_q == PH_MISS);
  assign match_idx   = idx_q;
  assign dispatch_en = disp_q;
  assign upload_en   = arm_q & (collecting | upfin_q);

endmodule

// File: rtl/opm_checker.sv
module opm_checker #(
  parameter int unsigned NumSlots = 24,
  parameter int unsigned OpBits   = 8,
  localparam int unsigned IdxW    = (NumSlots > 1) ? $clog2(NumSlots) : 1
) (
  input logic                       sck,
  input logic                       cs_n,
  input logic [NumSlots*OpBits-1:0] slot_opcode,
  input logic [NumSlots-1:0]        slot_valid,
  input logic [NumSlots-1:0]        slot_upload,
  input logic                       match_valid,
  input logic [IdxW-1:0]            match_idx,
  input logic                       nomatch,
  input logic                       dispatch_en,
  input logic                       upload_en
);
  // R1: quiet while deselected
  always @(posedge sck) begin
    if (cs_n === 1'b1) begin
      assert_idle_quiet_R1: assert (!match_valid && !nomatch && !dispatch_en &&
                                    !upload_en && match_idx == '0)
        else $error("idle outputs not cleared");
    end
  end

  assert_valid_slot_R3: assert property (@(posedge sck) disable iff (cs_n)
    match_valid |-> slot_valid[match_idx]);

  assert_dispatch_hit_R5: assert property (@(posedge sck) disable iff (cs_n)
    dispatch_en |-> match_valid);

  assert_dispatch_once_R5: assert property (@(posedge sck) disable iff (cs_n)
    dispatch_en |=> !dispatch_en);

  assert_upload_qual_R7: assert property (@(posedge sck) disable iff (cs_n)
    (match_valid && upload_en) |-> slot_upload[match_idx]);

  assert_miss_quiet_R8: assert property (@(posedge sck) disable iff (cs_n)
    nomatch |-> (!match_valid && !upload_en && !dispatch_en));

  assert_result_hold_R9: assert property (@(posedge sck) disable iff (cs_n)
    (match_valid || nomatch) |=> ($stable(match_valid) && $stable(nomatch) &&
                                  $stable(match_idx)));

endmodule

bind opm_opcode_matcher opm_checker #(
  .NumSlots(NumSlots),
  .OpBits  (OpBits)
) u_chk (
  .sck         (sck),
  .cs_n        (cs_n),
  .slot_opcode (slot_opcode),
  .slot_valid  (slot_valid),
  .slot_upload (slot_upload),
  .match_valid (match_valid),
  .match_idx   (match_idx),
  .nomatch     (nomatch),
  .dispatch_en (dispatch_en),
  .upload_en   (upload_en)
);

// File: tb/opm_opcode_matcher_tb.sv
module opm_opcode_matcher_tb;
  localparam int unsigned N    = 24;
  localparam int unsigned W    = 8;
  localparam int unsigned IdxW = 5;
  localparam int unsigned NV   = 14;
  localparam logic [7:0] VECS [NV] = '{
    8'h03, 8'h05, 8'h9F, 8'h06, 8'h04, 8'hC7, 8'h02,
    8'h20, 8'h00, 8'hFF, 8'hEA, 8'hEC, 8'hEB, 8'hF2
  };

  logic            sck = 1'b0;
  logic            cs_n;
  logic            sdi;
  logic [N*W-1:0]  slot_opcode;
  logic [N-1:0]    slot_valid, slot_upload;
  logic            match_valid, nomatch, dispatch_en, upload_en;
  logic [IdxW-1:0] match_idx;
  logic [7:0]      opc [N];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #4 sck = ~sck;

  always_comb begin
    for (int i = 0; i < N; i++) slot_opcode[i*W +: W] = opc[i];
  end

  opm_opcode_matcher #(.NumSlots(N), .OpBits(W)) u_dut (
    .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .slot_opcode(slot_opcode), .slot_valid(slot_valid), .slot_upload(slot_upload),
    .match_valid(match_valid), .match_idx(match_idx), .nomatch(nomatch),
    .dispatch_en(dispatch_en), .upload_en(upload_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Reference: full-byte compare, lowest valid slot wins
  task automatic model(input logic [7:0] op, output bit hit, output int idx,
                       output bit early, output bit up);
    hit = 0; idx = 0; early = 0; up = 0;
    for (int i = 0; i < N; i++) begin
      if (slot_valid[i] && slot_upload[i] && opc[i][7:1] == op[7:1]) early = 1;
      if (!hit && slot_valid[i] && opc[i] == op) begin
        hit = 1; idx = i; up = slot_upload[i];
      end
    end
  endtask

  task automatic send_op(input logic [7:0] op);
    bit hit, early, up;
    int idx;
    model(op, hit, idx, early, up);
    @(posedge sck); #1; cs_n = 1'b0; sdi = op[7];
    for (int b = 6; b >= 0; b--) begin
      @(posedge sck); #1; sdi = op[b];
    end
    chk("R6 upload low before 7th fall", upload_en, 0);
    chk("R2 no match before 8th bit", match_valid, 0);
    @(negedge sck); #1;
    chk("R6 early upload", upload_en, early);
    chk("R5 dispatch low before 8th bit", dispatch_en, 0);
    @(posedge sck); #1;
    chk("R2 match_valid", match_valid, hit);
    if (hit) chk("R2 R3 R4 match_idx", match_idx, idx);
    chk("R8 nomatch", nomatch, !hit);
    chk("R5 dispatch pulse", dispatch_en, hit);
    chk("R7 upload final", upload_en, early && up);
  endtask

  task automatic release_cs();
    @(posedge sck); #1; cs_n = 1'b1; #1;
    chk("R1 match_valid idle", match_valid, 0);
    chk("R1 upload idle", upload_en, 0);
    chk("R1 nomatch idle", nomatch, 0);
  endtask

  initial begin
    repeat (200000) @(posedge sck);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    cs_n = 1'b0; sdi = 1'b0;
    for (int i = 0; i < N; i++) begin
      opc[i] = 8'hE0 + 8'(i);
      slot_valid[i]  = (i % 2 == 0);
      slot_upload[i] = (i % 3 == 0);
    end
    opc[0] = 8'h03; slot_valid[0] = 1; slot_upload[0] = 0;
    opc[1] = 8'h05; slot_valid[1] = 1; slot_upload[1] = 0;
    opc[2] = 8'h9F; slot_valid[2] = 1; slot_upload[2] = 0;
    opc[3] = 8'h06; slot_valid[3] = 1; slot_upload[3] = 1;
    opc[4] = 8'h04; slot_valid[4] = 1; slot_upload[4] = 1;
    opc[5] = 8'hC7; slot_valid[5] = 1; slot_upload[5] = 1;
    opc[6] = 8'h02; slot_valid[6] = 1; slot_upload[6] = 1;
    opc[7] = 8'h20; slot_valid[7] = 0; slot_upload[7] = 1;
    opc[8] = 8'h05; slot_valid[8] = 1; slot_upload[8] = 1;
    #1 cs_n = 1'b1;
    @(posedge sck); #1;
    chk("R1 reset match_valid", match_valid, 0);
    chk("R1 reset nomatch", nomatch, 0);
    chk("R1 reset dispatch", dispatch_en, 0);
    chk("R1 reset upload", upload_en, 0);
    chk("R1 reset idx", match_idx, 0);

    for (int v = 0; v < NV; v++) begin
      send_op(VECS[v]);
      release_cs();
    end

    // R9: trailing bits after a hit
    send_op(8'h9F);
    for (int k = 0; k < 12; k++) begin
      @(posedge sck); #1; sdi = k[0] ^ k[2];
      if (k == 0) chk("R5 dispatch one cycle", dispatch_en, 0);
    end
    @(posedge sck); #1;
    chk("R9 hit held", match_valid, 1);
    chk("R9 idx held", match_idx, 2);
    release_cs();

    // R8/R9: miss held through trailing bits
    send_op(8'h00);
    for (int k = 0; k < 10; k++) begin
      @(posedge sck); #1; sdi = ~k[0];
    end
    @(posedge sck); #1;
    chk("R8 nomatch held", nomatch, 1);
    chk("R8 no dispatch on miss", dispatch_en, 0);
    chk("R9 no late match", match_valid, 0);
    release_cs();

    // R10: abort partway, then a fresh opcode
    @(posedge sck); #1; cs_n = 1'b0; sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(posedge sck); #1; sdi = k[0];
    end
    release_cs();
    send_op(8'h06);
    chk("R10 fresh match idx", match_idx, 3);
    chk("R10 fresh match", match_valid, 1);
    release_cs();

    finish_up();
  end

endmodule